// File: doc/BRIEF.md
# Self-Prescaling Square-Wave Tone Generator

This block turns a start command into a square wave on one of several output lines. The command carries a pitch in hertz, a length in milliseconds and the index of the line to drive. From a fixed base clock rate, the block derives two settings: a power-of-two prescale ratio and a compare value. The ratio is taken from a fixed set that has gaps. A match-frequency counter then toggles the chosen line each time it reaches the compare value.

A nonzero length is converted into a budget of half-periods. When that budget is spent, the block drives the line low and goes idle on its own. A length of zero makes the tone run until a stop command arrives.

Both divisions use one shared sequential divider, and `busy` is high while it works. A start that names a different line while a tone plays silences the old line first. Lines that are not selected stay low at all times.

Top module: `tone_gen`

## Requirements
- R1: With q = BASE_HZ / freq (integer division), the block tries the ratios in ascending order and picks the first one whose compare value (q >> k) − 1 is at most the compare top (2^CMP_W − 1). `ratio_log2` reports k, and `match_top` reports the compare value.
- R2: The only legal values of k are 0, 1, 2, 3, 4, 6, 8 and 10. Ratios 32, 128 and 512 are never chosen, even when one of them would fit.
- R3: If the compare value still exceeds the top at k = 10, the block uses k = 10 with a compare value of 2^CMP_W − 1.
- R4: While `active` is high, the selected line toggles once every (match_top + 1) × 2^ratio_log2 clock cycles.
- R5: A start with a nonzero length loads a budget of freq × dur × 2 / 1000 (integer arithmetic). The line makes exactly that many toggles. On the next match, the line is driven low and `active` falls on the same edge. While `active` is low, all lines are low.
- R6: A start with length 0 produces a tone that never ends on its own.
- R7: A stop input high at a clock edge drives every line low, clears `active` and `busy`, and halts the counter, all by that edge.
- R8: An accepted start drives every line low at the accepting edge. After setup, only the newly selected line toggles. At most one line is ever high.
- R9: `busy` is high from the accepting edge until the setup completes, and it is never high together with `active`. Starts that arrive while `busy` is high are ignored.
- R10: A start with freq = 0 has no effect: `busy` and `active` stay low, and the lines stay low.
- R11: After reset, every line, `busy` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at BASE_HZ |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled each cycle |
| start_freq | input | FREQ_W | Tone pitch in hertz |
| start_dur_ms | input | DUR_W | Tone length in ms, 0 = endless |
| start_sel | input | SEL_W | Index of the output line |
| stop | input | 1 | Silence the tone at the next edge |
| tone_out | output | N_OUT | Output lines, one-hot or zero |
| busy | output | 1 | Setup in progress |
| active | output | 1 | Tone playing |
| ratio_log2 | output | 4 | Chosen prescale exponent k |
| match_top | output | CMP_W | Chosen compare value |

## Verification
The bench builds the block with BASE_HZ = 300000, CMP_W = 8, FREQ_W = DUR_W = 16 and N_OUT = 4. The narrow 8-bit compare field makes the upper prescale steps reachable at low pitches. These include the skipped ratio 32 (a 50 Hz tone must land on ratio 64) and the saturation case at 1 Hz. Every half-period stays within a few thousand cycles, so periods, budgets and end-of-tone timing can all be measured cycle by cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int N_LEGAL   = 8;
    localparam int SHIFT_W   = 4;
    localparam int PRE_W     = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUOT = 2'd1,
        ST_BUDG = 2'd2,
        ST_RUN  = 2'd3
    } tone_state_t;

    // Legal prescale exponents in ascending order; 5, 7 and 9 are absent.
    function automatic logic [SHIFT_W-1:0] legal_shift(input int idx);
        case (idx)
            0:       legal_shift = 4'd0;
            1:       legal_shift = 4'd1;
            2:       legal_shift = 4'd2;
            3:       legal_shift = 4'd3;
            4:       legal_shift = 4'd4;
            5:       legal_shift = 4'd6;
            6:       legal_shift = 4'd8;
            default: legal_shift = 4'd10;
        endcase
    endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int W = 41
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W:0]    shifted;
    logic [W:0]    trial;
    logic [CW-1:0] left;
    logic          running;

    always_comb begin
        shifted = {rem[W-1:0], quot[W-1]};
        trial   = shifted - {1'b0, den};
    end

    // Restoring division, one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            quot    <= '0;
            left    <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem     <= '0;
                quot    <= num;
                left    <= CW'(W);
                running <= 1'b1;
            end else if (running) begin
                if (!trial[W]) begin
                    rem  <= trial;
                    quot <= {quot[W-2:0], 1'b1};
                end else begin
                    rem  <= shifted;
                    quot <= {quot[W-2:0], 1'b0};
                end
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tone_ratio_pick.sv
module tone_ratio_pick
    import tone_pkg::*;
#(
    parameter int Q_W   = 41,
    parameter int CMP_W = 16
) (
    input  logic [Q_W-1:0]     quot,
    output logic [SHIFT_W-1:0] shift,
    output logic [CMP_W-1:0]   top
);
    localparam logic [Q_W-1:0] TOP_LIM = Q_W'((64'(1) << CMP_W) - 64'(1));

    logic [Q_W-1:0] scaled;
    logic [Q_W-1:0] cand;
    logic           found;

    // First legal exponent whose compare value fits; saturate otherwise.
    always_comb begin
        shift  = SHIFT_W'(10);
        top    = '1;
        found  = 1'b0;
        scaled = '0;
        cand   = '0;
        for (int i = 0; i < N_LEGAL; i++) begin
            scaled = quot >> legal_shift(i);
            cand   = scaled - Q_W'(1);
            if (!found && scaled != '0 && cand <= TOP_LIM) begin
                shift = legal_shift(i);
                top   = CMP_W'(cand);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tone_match_timer.sv
module tone_match_timer
    import tone_pkg::*;
#(
    parameter int CMP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CMP_W-1:0]   top,
    output logic               hit
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] span;
    logic [CMP_W-1:0] cnt;
    logic             tick;

    always_comb begin
        span = (PRE_W'(1) << shift) - PRE_W'(1);
        tick = (pre == span);
        hit  = run && tick && (cnt == top);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= (cnt == top) ? '0 : cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/tone_lines.sv
module tone_lines #(
    parameter int N_OUT = 4,
    parameter int SEL_W = 2
) (
    input  logic             en,
    input  logic             level,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] lines
);
    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign lines[g] = en && level && (sel == SEL_W'(g));
    end

endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tone_pkg::*;
#(
    parameter int unsigned BASE_HZ = 48_000_000,
    parameter int          FREQ_W  = 20,
    parameter int          DUR_W   = 20,
    parameter int          CMP_W   = 16,
    parameter int          N_OUT   = 4,
    localparam int         SEL_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FREQ_W-1:0]  start_freq,
    input  logic [DUR_W-1:0]   start_dur_ms,
    input  logic [SEL_W-1:0]   start_sel,
    input  logic               stop,
    output logic [N_OUT-1:0]   tone_out,
    output logic               busy,
    output logic               active,
    output logic [3:0]         ratio_log2,
    output logic [CMP_W-1:0]   match_top
);
    localparam int DIV_W = FREQ_W + DUR_W + 1;

    tone_state_t        state;
    logic               level;
    logic               forever_q;
    logic [DIV_W-1:0]   budget;
    logic [SEL_W-1:0]   sel_q;
    logic [FREQ_W-1:0]  freq_q;
    logic [DUR_W-1:0]   dur_q;
    logic               div_go;
    logic [DIV_W-1:0]   div_num;
    logic [DIV_W-1:0]   div_den;
    logic               div_done;
    logic [DIV_W-1:0]   div_quot;
    logic [DIV_W-1:0]   quot_safe;
    logic [DIV_W-1:0]   prod;
    logic [SHIFT_W-1:0] pick_shift;
    logic [CMP_W-1:0]   pick_top;
    logic [SHIFT_W-1:0] shift_q;
    logic [CMP_W-1:0]   top_q;
    logic               hit;
    logic               accept;

    assign busy       = (state == ST_QUOT) || (state == ST_BUDG);
    assign active     = (state == ST_RUN);
    assign accept     = start && !busy && (start_freq != '0);
    assign quot_safe  = (div_quot == '0) ? DIV_W'(1) : div_quot;
    assign prod       = DIV_W'(freq_q) * DIV_W'(dur_q) * DIV_W'(2);
    assign ratio_log2 = shift_q;
    assign match_top  = top_q;

    tone_divider #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quot (div_quot)
    );

    tone_ratio_pick #(.Q_W(DIV_W), .CMP_W(CMP_W)) u_pick (
        .quot  (quot_safe),
        .shift (pick_shift),
        .top   (pick_top)
    );

    tone_match_timer #(.CMP_W(CMP_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (active),
        .shift (shift_q),
        .top   (top_q),
        .hit   (hit)
    );

    tone_lines #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_lines (
        .en    (active),
        .level (level),
        .sel   (sel_q),
        .lines (tone_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            level     <= 1'b0;
            forever_q <= 1'b0;
            budget    <= '0;
            sel_q     <= '0;
            freq_q    <= '0;
            dur_q     <= '0;
            div_go    <= 1'b0;
            div_num   <= '0;
            div_den   <= '0;
            shift_q   <= '0;
            top_q     <= '0;
        end else begin
            div_go <= 1'b0;
            if (stop) begin
                state <= ST_IDLE;
                level <= 1'b0;
            end else if (accept) begin
                state   <= ST_QUOT;
                level   <= 1'b0;
                sel_q   <= start_sel;
                freq_q  <= start_freq;
                dur_q   <= start_dur_ms;
                div_go  <= 1'b1;
                div_num <= DIV_W'(BASE_HZ);
                div_den <= DIV_W'(start_freq);
            end else begin
                case (state)
                    ST_QUOT: begin
                        if (div_done) begin
                            shift_q <= pick_shift;
                            top_q   <= pick_top;
                            if (dur_q == '0) begin
                                forever_q <= 1'b1;
                                budget    <= '0;
                                state     <= ST_RUN;
                            end else begin
                                forever_q <= 1'b0;
                                div_go    <= 1'b1;
                                div_num   <= prod;
                                div_den   <= DIV_W'(1000);
                                state     <= ST_BUDG;
                            end
                        end
                    end
                    ST_BUDG: begin
                        if (div_done) begin
                            budget <= div_quot;
                            state  <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (hit) begin
                            if (forever_q || budget != '0) begin
                                level <= ~level;
                                if (!forever_q) begin
                                    budget <= budget - 1'b1;
                                end
                            end else begin
                                level <= 1'b0;
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
    parameter int FREQ_W = 20,
    parameter int N_OUT  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [FREQ_W-1:0] start_freq,
    input logic              stop,
    input logic [N_OUT-1:0]  tone_out,
    input logic              busy,
    input logic              active,
    input logic [3:0]        ratio_log2
);
    AST_LEGAL_RATIO: assert property (@(posedge clk) disable iff (rst)
        active |-> (ratio_log2 inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd10})); // R2

    AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |-> (tone_out == '0)); // R5

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (rst)
        stop |=> (tone_out == '0) && !active && !busy); // R7

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && start_freq != '0 && !busy && !stop) |=> busy && (tone_out == '0)); // R8

    AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (rst)
        $countones(tone_out) <= 1); // R8

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !active); // R9

    AST_ZERO_FREQ: assert property (@(posedge clk) disable iff (rst)
        (start && start_freq == '0 && !busy && !active && !stop) |=> !busy && !active); // R10

endmodule

bind tone_gen tone_gen_chk #(.FREQ_W(FREQ_W), .N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_freq (start_freq),
    .stop       (stop),
    .tone_out   (tone_out),
    .busy       (busy),
    .active     (active),
    .ratio_log2 (ratio_log2)
);

// File: tb/sim_tone_gen.sv
module sim_tone_gen;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned BASE_HZ = 300_000;
    localparam int FREQ_W = 16;
    localparam int DUR_W  = 16;
    localparam int CMP_W  = 8;
    localparam int N_OUT  = 4;
    localparam int SEL_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] start_freq = '0;
    logic [DUR_W-1:0]  start_dur_ms = '0;
    logic [SEL_W-1:0]  start_sel = '0;
    logic              stop = 1'b0;
    logic [N_OUT-1:0]  tone_out;
    logic              busy;
    logic              active;
    logic [3:0]        ratio_log2;
    logic [CMP_W-1:0]  match_top;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    tone_gen #(.BASE_HZ(BASE_HZ), .FREQ_W(FREQ_W), .DUR_W(DUR_W),
               .CMP_W(CMP_W), .N_OUT(N_OUT)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_freq(start_freq),
        .start_dur_ms(start_dur_ms), .start_sel(start_sel), .stop(stop),
        .tone_out(tone_out), .busy(busy), .active(active),
        .ratio_log2(ratio_log2), .match_top(match_top)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input int f, input int d, input int sel);
        @(negedge clk);
        start = 1'b1;
        start_freq = FREQ_W'(f);
        start_dur_ms = DUR_W'(d);
        start_sel = SEL_W'(sel);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_setup();
        for (int i = 0; i < 500; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic do_stop(input string tag);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(tone_out == '0 && !active && !busy, tag, {tone_out, active, busy}, 0);
    endtask

    task automatic watch(input int sel, input int half, input int limit, input int maxc,
                         output int toggles, output int bad_iv, output int others,
                         output bit ended, output int end_gap);
        logic prev;
        int   since;
        bit   seen;
        toggles = 0; bad_iv = 0; others = 0; ended = 1'b0; end_gap = -1;
        prev = tone_out[sel]; since = 0; seen = 1'b0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            since++;
            if ((tone_out & ~(N_OUT'(1) << sel)) != '0) others++;
            if (!active) begin
                ended = 1'b1;
                end_gap = since;
                break;
            end
            if (tone_out[sel] !== prev) begin
                toggles++;
                if (seen && since != half) bad_iv++;
                seen = 1'b1;
                since = 0;
                prev = tone_out[sel];
            end
            if (limit != 0 && toggles >= limit) break;
        end
    endtask

    task automatic t_reset();
        check(tone_out == '0, "R11 lines low", tone_out, 0);
        check(!busy, "R11 busy low", busy, 0);
        check(!active, "R11 active low", active, 0);
    endtask

    task automatic t_finite_even();
        int tg, bi, ot, gap; bit en;
        pulse_start(3000, 2, 1);
        wait_setup();
        check(ratio_log2 == 0 && match_top == 99, "R1 pick 3000Hz", {ratio_log2, match_top}, 99);
        watch(1, 100, 0, 3000, tg, bi, ot, en, gap);
        check(tg == 12, "R5 budget 12", tg, 12);
        check(bi == 0, "R4 interval 100", bi, 0);
        check(en && gap == 100, "R5 end one half-period later", gap, 100);
        check(ot == 0 && tone_out == '0, "R8 other lines low", ot, 0);
    endtask

    task automatic t_finite_odd();
        int tg, bi, ot, gap; bit en;
        pulse_start(1500, 1, 2);
        wait_setup();
        check(match_top == 199, "R1 pick 1500Hz", match_top, 199);
        watch(2, 200, 0, 3000, tg, bi, ot, en, gap);
        check(tg == 3, "R5 odd budget 3", tg, 3);
        check(en && gap == 200 && tone_out == '0, "R5 forced low at end", gap, 200);
    endtask

    task automatic t_prescaled();
        int tg, bi, ot, gap; bit en;
        pulse_start(1000, 1, 0);
        wait_setup();
        check(ratio_log2 == 1 && match_top == 149, "R1 ratio 2 for 1000Hz", {ratio_log2, match_top}, {4'd1, 8'd149});
        watch(0, 300, 0, 3000, tg, bi, ot, en, gap);
        check(tg == 2 && bi == 0 && gap == 300, "R4 prescaled period 300", {tg, bi, gap}, 300);
    endtask

    task automatic t_gap_forever();
        int tg, bi, ot, gap; bit en;
        pulse_start(50, 0, 2);
        wait_setup();
        check(ratio_log2 == 6, "R2 ratio 32 skipped", ratio_log2, 6);
        check(match_top == 92, "R2 compare at ratio 64", match_top, 92);
        watch(2, 5952, 4, 40000, tg, bi, ot, en, gap);
        check(tg == 4 && bi == 0 && !en && active, "R6 endless tone keeps going", tg, 4);
        do_stop("R7 stop silences");
    endtask

    task automatic t_saturate();
        pulse_start(1, 0, 3);
        wait_setup();
        check(ratio_log2 == 10 && match_top == 255, "R3 saturate at 1024", {ratio_log2, match_top}, {4'd10, 8'd255});
        check(active, "R3 tone running", active, 1);
        do_stop("R7 stop after saturation");
    endtask

    task automatic t_zero_freq();
        pulse_start(0, 5, 1);
        check(!busy && !active, "R10 zero freq no setup", {busy, active}, 0);
        repeat (50) @(negedge clk);
        check(!active && tone_out == '0, "R10 still silent", tone_out, 0);
    endtask

    task automatic t_busy_and_switch();
        int tg, bi, ot, gap; bit en;
        pulse_start(3000, 0, 0);
        check(busy, "R9 busy after accept", busy, 1);
        pulse_start(1500, 0, 3);
        wait_setup();
        check(match_top == 99 && active, "R9 start while busy ignored", match_top, 99);
        watch(0, 100, 3, 2000, tg, bi, ot, en, gap);
        check(tg == 3 && bi == 0 && ot == 0, "R9 line 0 plays", tg, 3);
        pulse_start(1500, 0, 3);
        check(tone_out == '0 && busy, "R8 switch silences lines", tone_out, 0);
        wait_setup();
        check(match_top == 199, "R8 new setup", match_top, 199);
        watch(3, 200, 3, 2000, tg, bi, ot, en, gap);
        check(tg == 3 && bi == 0 && ot == 0, "R8 only line 3 toggles", {tg, ot}, 3);
        do_stop("R7 stop after switch");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_finite_even();
        t_finite_odd();
        t_prescaled();
        t_gap_forever();
        t_saturate();
        t_zero_freq();
        t_busy_and_switch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule